// File: doc/BRIEF.md
# Burst-Mode Coarse Frequency Lock Controller

This block is the coarse digital loop of an all-digital PLL whose oscillator is powered for only a short window out of every frame. A scheduler counts reference strobes and opens an oscillator window that lasts exactly one reference period in every ten. During that window, single-cycle oscillator edge strobes (already in the system clock domain) are tallied.

When the window closes, the block compares the tally against the programmed frequency control word. The signed difference is folded into a saturating accumulator, and the accumulator's value is the coarse oscillator control code. A tally that is one above the target counts as on target, because edge counting cannot resolve less than one edge.

The code changes only once per frame, right after a window closes, so the oscillator starts the next burst from that setting. A lock flag reports when consecutive bursts have landed on target.

Top module: `burst_freq_lock`

## Requirements
- R1: After reset `osc_en` is low. The first `ref_tick` raises it in the following cycle. It stays high until the next `ref_tick` and falls in the cycle after that one. It then stays low across nine more reference periods, and the pattern repeats every ten `ref_tick` strobes.
- R2: An `osc_edge` strobe is counted only in a cycle where `osc_en` is high, and this includes the cycle of the closing `ref_tick`. Strobes while `osc_en` is low, including the cycle of the opening `ref_tick`, have no effect. The count saturates at 2^CNT_W-1.
- R3: At the closing `ref_tick` the error is `fcw` minus the count. `coarse_code` moves by that error one clock later.
- R4: A count equal to `fcw` or to `fcw`+1 gives zero error and leaves `coarse_code` unchanged.
- R5: `coarse_code` does not change between the update that follows one burst and the next closing `ref_tick`.
- R6: `coarse_code` is a 7-bit unsigned value that saturates at 0 and at 127 instead of wrapping.
- R7: `coarse_lock` rises after two consecutive zero-error bursts. It falls at the first burst with a nonzero error and changes only in the cycle after a burst closes.
- R8: Synchronous reset (`rst` high) sets `coarse_code` to 64 and clears `coarse_lock`, `osc_en` and the edge count.
- R9: The edge count starts from zero in every burst, so edges from earlier bursts never add to the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_tick | input | 1 | One-cycle strobe at each reference edge |
| osc_edge | input | 1 | One-cycle strobe per oscillator rising edge |
| fcw | input | 8 | Target edge count per burst |
| osc_en | output | 1 | Oscillator burst enable |
| coarse_code | output | 7 | Coarse DAC control code |
| coarse_lock | output | 1 | Coarse frequency lock flag |

## Verification
The assertions assume that `ref_tick` is a single-cycle pulse and that `osc_edge` carries at most one edge per system clock. They also assume that `fcw` is steady in the cycle a burst closes. The stimulus spaces reference strobes forty clocks apart, issues at most one edge strobe per cycle, and changes `fcw` only at the start of a frame. Edges are packed at either end of the window so that both the opening and closing cycles are exercised. Stray strobes are scattered through the idle part of the frame.

// File: rtl/bfl_pkg.sv
package bfl_pkg;
    localparam int DEF_CODE_W    = 7;
    localparam int DEF_CNT_W     = 8;
    localparam int DEF_FRAME     = 10;
    localparam int DEF_LOCK_RUNS = 2;

    // mid-scale value of an unsigned code of width w
    function automatic int code_mid(input int w);
        return 1 << (w - 1);
    endfunction
endpackage

// File: rtl/bfl_sched.sv
module bfl_sched
    import bfl_pkg::*;
#(
    parameter int FRAME = DEF_FRAME
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_tick,
    output logic osc_en,
    output logic burst_start,
    output logic burst_end
);
    localparam int SLOT_W = $clog2(FRAME);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
    } sched_t;

    sched_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ref_tick) begin
            s_d.slot = (s_q.slot == LAST) ? '0 : s_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q.slot <= LAST;
        else     s_q      <= s_d;
    end

    assign osc_en      = (s_q.slot == '0);
    assign burst_start = ref_tick && (s_q.slot == LAST);
    assign burst_end   = ref_tick && (s_q.slot == '0);

    // R1: the enable moves only on a reference strobe
    a_r1_en_on_ref: assert property (@(posedge clk) disable iff (rst)
        !ref_tick |=> $stable(osc_en));
    // R1: a window opens after its opening strobe and closes after its closing one
    a_r1_open: assert property (@(posedge clk) disable iff (rst)
        burst_start |=> osc_en);
    a_r1_close: assert property (@(posedge clk) disable iff (rst)
        burst_end |=> !osc_en);
endmodule

// File: rtl/bfl_tally.sv
module bfl_tally
    import bfl_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             window,
    input  logic             clear,
    input  logic             osc_edge,
    output logic [CNT_W-1:0] total
);
    localparam logic [CNT_W-1:0] FULL = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tally_t;

    tally_t t_d, t_q;
    logic   bump;

    assign bump = window && osc_edge && (t_q.cnt != FULL);

    always_comb begin
        t_d = t_q;
        if (clear)     t_d.cnt = '0;
        else if (bump) t_d.cnt = t_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) t_q.cnt <= '0;
        else     t_q     <= t_d;
    end

    // count including an edge in the current (closing) cycle
    assign total = bump ? t_q.cnt + 1'b1 : t_q.cnt;

    a_r9_fresh_count: assert property (@(posedge clk) disable iff (rst)
        clear |=> (t_q.cnt == '0));
    a_r2_idle_ignored: assert property (@(posedge clk) disable iff (rst)
        (!window && !clear) |=> $stable(t_q.cnt));
    a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
        (window && !clear) |=> (t_q.cnt - $past(t_q.cnt)) <= CNT_W'(1));
endmodule

// File: rtl/bfl_accum.sv
module bfl_accum
    import bfl_pkg::*;
#(
    parameter int CODE_W    = DEF_CODE_W,
    parameter int CNT_W     = DEF_CNT_W,
    parameter int LOCK_RUNS = DEF_LOCK_RUNS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample,
    input  logic [CNT_W-1:0]  fcw,
    input  logic [CNT_W-1:0]  total,
    output logic [CODE_W-1:0] code,
    output logic              lock
);
    localparam int ERR_W  = CNT_W + 2;
    localparam int SUM_W  = ((ERR_W > CODE_W + 1) ? ERR_W : CODE_W + 1) + 1;
    localparam int RUN_W  = $clog2(LOCK_RUNS + 1);
    localparam int CODE_MAX = (1 << CODE_W) - 1;
    localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(code_mid(CODE_W));
    localparam logic signed [SUM_W-1:0] SUM_MAX = SUM_W'(CODE_MAX);
    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(LOCK_RUNS);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [RUN_W-1:0]  run;
    } acc_t;

    acc_t acc_d, acc_q;
    logic signed [ERR_W-1:0] err;
    logic signed [SUM_W-1:0] sum;
    logic                    one_over;

    always_comb begin
        one_over = ({1'b0, total} == ({1'b0, fcw} + (CNT_W + 1)'(1)));
        if (one_over) err = '0;
        else          err = $signed({2'b00, fcw}) - $signed({2'b00, total});
        sum = $signed({{(SUM_W - CODE_W){1'b0}}, acc_q.code})
            + $signed({{(SUM_W - ERR_W){err[ERR_W-1]}}, err});

        acc_d = acc_q;
        if (sample) begin
            if (sum < 0)            acc_d.code = '0;
            else if (sum > SUM_MAX) acc_d.code = '1;
            else                    acc_d.code = sum[CODE_W-1:0];

            if (err != '0)                acc_d.run = '0;
            else if (acc_q.run != RUN_FULL) acc_d.run = acc_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q.code <= CODE_MID;
            acc_q.run  <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign code = acc_q.code;
    assign lock = (acc_q.run == RUN_FULL);

    a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !sample |=> $stable(acc_q.code));
    a_r4_zero_keeps: assert property (@(posedge clk) disable iff (rst)
        (sample && err == '0) |=> $stable(acc_q.code));
    a_r6_no_wrap_up: assert property (@(posedge clk) disable iff (rst)
        (sample && err > 0) |=> acc_q.code >= $past(acc_q.code));
    a_r6_no_wrap_down: assert property (@(posedge clk) disable iff (rst)
        (sample && err < 0) |=> acc_q.code <= $past(acc_q.code));
    a_r7_lock_drops: assert property (@(posedge clk) disable iff (rst)
        (sample && err != '0) |=> !lock);
    a_r7_lock_steady: assert property (@(posedge clk) disable iff (rst)
        !sample |=> $stable(lock));
endmodule

// File: rtl/burst_freq_lock.sv
module burst_freq_lock
    import bfl_pkg::*;
#(
    parameter int CODE_W    = DEF_CODE_W,
    parameter int CNT_W     = DEF_CNT_W,
    parameter int FRAME     = DEF_FRAME,
    parameter int LOCK_RUNS = DEF_LOCK_RUNS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              osc_edge,
    input  logic [CNT_W-1:0]  fcw,
    output logic              osc_en,
    output logic [CODE_W-1:0] coarse_code,
    output logic              coarse_lock
);
    logic             burst_start;
    logic             burst_end;
    logic [CNT_W-1:0] total;

    bfl_sched #(.FRAME(FRAME)) u_sched (
        .clk        (clk),
        .rst        (rst),
        .ref_tick   (ref_tick),
        .osc_en     (osc_en),
        .burst_start(burst_start),
        .burst_end  (burst_end)
    );

    bfl_tally #(.CNT_W(CNT_W)) u_tally (
        .clk     (clk),
        .rst     (rst),
        .window  (osc_en),
        .clear   (burst_start),
        .osc_edge(osc_edge),
        .total   (total)
    );

    bfl_accum #(
        .CODE_W   (CODE_W),
        .CNT_W    (CNT_W),
        .LOCK_RUNS(LOCK_RUNS)
    ) u_accum (
        .clk   (clk),
        .rst   (rst),
        .sample(burst_end),
        .fcw   (fcw),
        .total (total),
        .code  (coarse_code),
        .lock  (coarse_lock)
    );

    a_r8_reset_state: assert property (@(posedge clk)
        rst |=> (coarse_code == CODE_W'(code_mid(CODE_W))) && !coarse_lock && !osc_en);
endmodule

// File: tb/sim_burst_freq_lock.sv
module sim_burst_freq_lock;
    localparam int REF_DIV = 40;
    localparam int FRAME   = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       ref_tick;
    logic       osc_edge;
    logic [7:0] fcw;
    logic       osc_en;
    logic [6:0] coarse_code;
    logic       coarse_lock;

    int  n_chk = 0;
    int  n_bad = 0;
    int  m_code = 64;
    int  m_run  = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    burst_freq_lock u0 (
        .clk        (clk),
        .rst        (rst),
        .ref_tick   (ref_tick),
        .osc_edge   (osc_edge),
        .fcw        (fcw),
        .osc_en     (osc_en),
        .coarse_code(coarse_code),
        .coarse_lock(coarse_lock)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int model_err(input int f, input int n);
        if (n == f + 1) return 0;
        return f - n;
    endfunction

    function automatic int clamp_code(input int v);
        if (v < 0)   return 0;
        if (v > 127) return 127;
        return v;
    endfunction

    // one full frame: burst of REF_DIV cycles, then nine idle periods
    // mode 0 packs n edges at the window start, mode 1 at its end
    task automatic frame(input string tag, input int f, input int n,
                         input int mode, input int stray_pct);
        fcw = f[7:0];
        for (int k = 0; k < FRAME; k++) begin
            for (int i = 0; i < REF_DIV; i++) begin
                @(negedge clk);
                if (k == 0 && i == REF_DIV / 2)
                    check("R1 enable high in burst", int'(osc_en), 1);
                if (k == 1 && i == 1) begin
                    int e;
                    e = model_err(f, n);
                    m_code = clamp_code(m_code + e);
                    if (e != 0) m_run = 0;
                    else if (m_run < 2) m_run++;
                    check(tag, int'(coarse_code), m_code);
                    check("R7 lock flag", int'(coarse_lock), (m_run >= 2) ? 1 : 0);
                    check("R1 enable low after close", int'(osc_en), 0);
                end
                if (k == 6 && i == 3) begin
                    check("R5 code held while idle", int'(coarse_code), m_code);
                    check("R1 enable low while idle", int'(osc_en), 0);
                end
                ref_tick = (i == 0);
                if ((k == 0 && i >= 1) || (k == 1 && i == 0)) begin
                    int j;
                    j = (k == 0) ? i - 1 : REF_DIV - 1;
                    osc_edge = (mode == 0) ? (j < n) : (j >= REF_DIV - n);
                end else begin
                    osc_edge = (stray_pct > 0) && ($urandom_range(99) < stray_pct);
                end
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ref_tick = 1'b0; osc_edge = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_code = 64;
        m_run  = 0;
        @(negedge clk);
        check("R8 reset code", int'(coarse_code), 64);
        check("R8 reset lock", int'(coarse_lock), 0);
        check("R8 reset enable", int'(osc_en), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; ref_tick = 1'b0; osc_edge = 1'b0; fcw = 8'd0;
        do_reset();

        // R1: no reference strobes, no burst
        repeat (20) @(negedge clk);
        check("R1 no burst without reference", int'(osc_en), 0);

        // R7: two on-target bursts give lock; R4: one-over is on target
        frame("R3 on target", 20, 20, 0, 0);
        frame("R7 second on target", 20, 20, 1, 0);
        frame("R4 count one over target", 20, 21, 0, 0);
        frame("R3 count high lowers code", 20, 25, 1, 0);
        frame("R3 count low raises code", 20, 12, 0, 0);
        // R2: edges on closing cycle counted, stray idle edges ignored
        frame("R2 stray edges ignored", 15, 15, 1, 30);
        frame("R2 tail edges counted", 15, 16, 1, 40);
        // R9: a big burst followed by a small one
        frame("R9 large burst", 30, 30, 0, 0);
        frame("R9 small burst after large", 10, 10, 1, 0);
        // R6: saturation at both ends
        for (int r = 0; r < 3; r++) frame("R6 saturate high", 40, 0, 0, 0);
        for (int r = 0; r < 5; r++) frame("R6 saturate low", 0, 40, 1, 0);

        // R8: reset in the middle of a burst
        fcw = 8'd25;
        @(negedge clk); ref_tick = 1'b1;
        @(negedge clk); ref_tick = 1'b0; osc_edge = 1'b1;
        repeat (5) @(negedge clk);
        do_reset();

        for (int r = 0; r < 30; r++) begin
            int f;
            int n;
            f = $urandom_range(45);
            n = $urandom_range(REF_DIV);
            if ($urandom_range(3) == 0) n = (f < REF_DIV) ? f + int'($urandom_range(1)) : REF_DIV;
            frame("R3 random burst", f, n, int'($urandom_range(1)), int'($urandom_range(50)));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule